// File: doc/BRIEF.md
# Dual-Thread Tagged Translation Buffer

A fully associative translation buffer shared by the two hardware threads of one SMT core. Each thread owns a page-table base register; the low 12 bits of that register are the thread's process-context identifier (PCID). Every entry records the PCID that was current for the filling thread. A lookup therefore only matches translations of the requester's own address space. Both threads can keep translations from different processes resident at once, and a context switch needs no flush.

The block has four kinds of port. Each thread has its own lookup port and its own base-register write port. Both threads share one fill port, which carries a request per thread. A single invalidate port serves both threads. A mode input selects between two ways of sharing the entries. In the first, the entries are split statically: thread 0 owns the lower half and thread 1 the upper half. In the second, the threads compete for all entries and only the PCID tag keeps their translations apart. Page walking and permission bits lie outside the block.

Top module: `smt_tlb`

## Requirements
- R1: After reset every entry is invalid, both base registers read zero, and `rsp_hit_o`/`rsp_miss_o` are low until a lookup is made.
- R2: A lookup issued in one cycle produces exactly one of hit or miss on that thread's response in the next cycle. No lookup means neither flag is set. A miss is reported when no entry matches.
- R3: A lookup hits only when an entry is valid, its virtual page number equals the request, and its stored PCID equals bits [11:0] of the requesting thread's base register. A hit returns the stored physical page number.
- R4: The two threads can hold translations for the same virtual page under different PCIDs at the same time, and each thread gets its own physical page.
- R5: Writing a base register never invalidates entries. Returning to an earlier PCID hits its old translations again. A write takes effect for lookups in the following cycle.
- R6: With `mode_shared_i`=0, thread 0 allocates and hits only in entries 0..N/2-1, and thread 1 only in entries N/2..N-1. A thread misses on a page that the other thread filled, even under an equal PCID.
- R7: With `mode_shared_i`=1, either thread allocates and hits in any entry, so one thread can keep all N translations resident.
- R8: A fill is placed in the lowest-numbered invalid entry of the allowed region. If the region is full, the fill goes to a round-robin victim. The pointer for this victim covers all entries in shared mode, and there is one pointer per half in partitioned mode.
- R9: The invalidate port has three operations, chosen by `inv_op_i`, and each completes in one cycle. Code 0 flushes every entry. Code 1 flushes entries whose PCID equals `inv_pcid_i`. Code 2 flushes the entry matching both `inv_vpn_i` and `inv_pcid_i`.
- R10: A fill is visible to lookups in the next cycle. A refill of a page already present for the same PCID overwrites that entry in place with the new physical page.
- R11: When both threads fill in the same cycle, thread 0 is written in that cycle and thread 1 in the next cycle, using the PCID captured at request time. Thread 1 issues no new fill while its fill is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_shared_i | input | 1 | 1: competitive sharing, 0: static half split |
| lk_valid_i | input | 2 | Lookup request per thread |
| lk_vpn_i | input | 2x36 | Lookup virtual page number per thread |
| rsp_hit_o | output | 2 | Registered hit per thread |
| rsp_miss_o | output | 2 | Registered miss per thread |
| rsp_ppn_o | output | 2x28 | Registered physical page number per thread |
| fill_valid_i | input | 2 | Fill request per thread |
| fill_vpn_i | input | 2x36 | Fill virtual page number per thread |
| fill_ppn_i | input | 2x28 | Fill physical page number per thread |
| cr3_we_i | input | 2 | Base-register write enable per thread |
| cr3_data_i | input | 2x64 | Base-register write data per thread |
| inv_valid_i | input | 1 | Invalidate request |
| inv_op_i | input | 2 | 0 all, 1 by PCID, 2 single page |
| inv_pcid_i | input | 12 | PCID operand of invalidate |
| inv_vpn_i | input | 36 | Page operand of invalidate |

## Verification
Each result has a fixed cycle in which it appears:

- A lookup response is due on the cycle after the request.
- A fill, a base-register write or an invalidate changes the results only of lookups issued after its clock edge.
- A thread-1 fill that collides with a thread-0 fill lands one edge later still.

The bench drives every input on the falling edge and holds it across exactly one rising edge. It samples each response at the next falling edge. In the collision case it places a lookup between the two write edges, which shows that the held fill is not yet visible.

// File: rtl/smt_tlb_pkg.sv
package smt_tlb_pkg;
  localparam int NT = 2;
  typedef enum logic [1:0] {
    INV_ALL  = 2'd0,
    INV_PCID = 2'd1,
    INV_PAGE = 2'd2
  } inv_op_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 36,
  parameter int PCID_W = 12,
  parameter int IDX_W  = 4
) (
  input  logic [N-1:0]             valid_i,
  input  logic [N-1:0][VPN_W-1:0]  vpn_tab_i,
  input  logic [N-1:0][PCID_W-1:0] pcid_tab_i,
  input  logic [N-1:0]             allow_i,
  input  logic [VPN_W-1:0]         vpn_i,
  input  logic [PCID_W-1:0]        pcid_i,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [N-1:0] m;
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      m[i] = valid_i[i] && allow_i[i] && vpn_tab_i[i] == vpn_i && pcid_tab_i[i] == pcid_i;
    for (int i = N-1; i >= 0; i--)
      if (m[i]) idx_o = IDX_W'(i);
    hit_o = |m;
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     valid_i,
  input  logic [N-1:0]     allow_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             use_ptr_o
);
  logic [N-1:0] free;
  always_comb begin
    free  = ~valid_i & allow_i;
    idx_o = ptr_i;
    for (int i = N-1; i >= 0; i--)
      if (free[i]) idx_o = IDX_W'(i);
    use_ptr_o = ~|free;
  end
endmodule

// File: rtl/smt_tlb.sv
module smt_tlb
  import smt_tlb_pkg::*;
#(
  parameter int N      = 16,
  parameter int VPN_W  = 36,
  parameter int PPN_W  = 28,
  parameter int PCID_W = 12,
  parameter int CR3_W  = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       mode_shared_i,
  input  logic [NT-1:0]              lk_valid_i,
  input  logic [NT-1:0][VPN_W-1:0]   lk_vpn_i,
  output logic [NT-1:0]              rsp_hit_o,
  output logic [NT-1:0]              rsp_miss_o,
  output logic [NT-1:0][PPN_W-1:0]   rsp_ppn_o,
  input  logic [NT-1:0]              fill_valid_i,
  input  logic [NT-1:0][VPN_W-1:0]   fill_vpn_i,
  input  logic [NT-1:0][PPN_W-1:0]   fill_ppn_i,
  input  logic [NT-1:0]              cr3_we_i,
  input  logic [NT-1:0][CR3_W-1:0]   cr3_data_i,
  input  logic                       inv_valid_i,
  input  logic [1:0]                 inv_op_i,
  input  logic [PCID_W-1:0]          inv_pcid_i,
  input  logic [VPN_W-1:0]           inv_vpn_i
);
  localparam int IDX_W = $clog2(N);
  localparam int HALF  = N / 2;

  logic [N-1:0]             valid_q, valid_inv, valid_d;
  logic [N-1:0][VPN_W-1:0]  vpn_q;
  logic [N-1:0][PPN_W-1:0]  ppn_q;
  logic [N-1:0][PCID_W-1:0] pcid_q;
  logic [NT-1:0][CR3_W-1:0] cr3_q;
  logic [IDX_W-1:0]         ptr_all_q, ptr_lo_q, ptr_hi_q, ptr_sel;

  logic                     pend_q;
  logic [VPN_W-1:0]         pend_vpn_q;
  logic [PPN_W-1:0]         pend_ppn_q;
  logic [PCID_W-1:0]        pend_pcid_q;

  logic [N-1:0]             lo_mask;
  logic [NT-1:0][N-1:0]     allow;
  logic [NT-1:0][PCID_W-1:0] cur_pcid;
  logic [NT-1:0]            lk_hit;
  logic [NT-1:0][IDX_W-1:0] lk_idx;

  logic                     wr_en, wr_thread, wr_hit, use_ptr;
  logic [VPN_W-1:0]         wr_vpn;
  logic [PPN_W-1:0]         wr_ppn;
  logic [PCID_W-1:0]        wr_pcid;
  logic [IDX_W-1:0]         wr_idx, hit_idx, vic_idx;

  always_comb begin
    for (int i = 0; i < N; i++) lo_mask[i] = (i < HALF);
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    assign cur_pcid[t] = cr3_q[t][PCID_W-1:0];
    if (t == 0) begin : g_lo
      assign allow[t] = mode_shared_i ? '1 : lo_mask;
    end else begin : g_hi
      assign allow[t] = mode_shared_i ? '1 : ~lo_mask;
    end
    tlb_match #(.N(N), .VPN_W(VPN_W), .PCID_W(PCID_W), .IDX_W(IDX_W)) lk_match_i (
      .valid_i(valid_q), .vpn_tab_i(vpn_q), .pcid_tab_i(pcid_q), .allow_i(allow[t]),
      .vpn_i(lk_vpn_i[t]), .pcid_i(cur_pcid[t]), .hit_o(lk_hit[t]), .idx_o(lk_idx[t]));
  end

  // invalidate precedes the fill of the same cycle
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic kill;
      unique case (inv_op_i)
        INV_ALL:  kill = 1'b1;
        INV_PCID: kill = pcid_q[i] == inv_pcid_i;
        INV_PAGE: kill = pcid_q[i] == inv_pcid_i && vpn_q[i] == inv_vpn_i;
        default:  kill = 1'b0;
      endcase
      valid_inv[i] = valid_q[i] && !(inv_valid_i && kill);
    end
  end

  // fill arbitration: thread 0, then held thread 1, then fresh thread 1
  always_comb begin
    wr_en = 1'b0; wr_thread = 1'b0;
    wr_vpn = fill_vpn_i[0]; wr_ppn = fill_ppn_i[0]; wr_pcid = cur_pcid[0];
    if (fill_valid_i[0]) begin
      wr_en = 1'b1;
    end else if (pend_q) begin
      wr_en = 1'b1; wr_thread = 1'b1;
      wr_vpn = pend_vpn_q; wr_ppn = pend_ppn_q; wr_pcid = pend_pcid_q;
    end else if (fill_valid_i[1]) begin
      wr_en = 1'b1; wr_thread = 1'b1;
      wr_vpn = fill_vpn_i[1]; wr_ppn = fill_ppn_i[1]; wr_pcid = cur_pcid[1];
    end
  end

  assign ptr_sel = mode_shared_i ? ptr_all_q : (wr_thread ? ptr_hi_q : ptr_lo_q);

  tlb_match #(.N(N), .VPN_W(VPN_W), .PCID_W(PCID_W), .IDX_W(IDX_W)) wr_match_i (
    .valid_i(valid_inv), .vpn_tab_i(vpn_q), .pcid_tab_i(pcid_q), .allow_i(allow[wr_thread]),
    .vpn_i(wr_vpn), .pcid_i(wr_pcid), .hit_o(wr_hit), .idx_o(hit_idx));

  tlb_victim #(.N(N), .IDX_W(IDX_W)) victim_i (
    .valid_i(valid_inv), .allow_i(allow[wr_thread]), .ptr_i(ptr_sel),
    .idx_o(vic_idx), .use_ptr_o(use_ptr));

  assign wr_idx = wr_hit ? hit_idx : vic_idx;

  always_comb begin
    valid_d = valid_inv;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q     <= '0;
      vpn_q       <= '0;
      ppn_q       <= '0;
      pcid_q      <= '0;
      cr3_q       <= '0;
      ptr_all_q   <= '0;
      ptr_lo_q    <= '0;
      ptr_hi_q    <= IDX_W'(HALF);
      pend_q      <= 1'b0;
      pend_vpn_q  <= '0;
      pend_ppn_q  <= '0;
      pend_pcid_q <= '0;
      rsp_hit_o   <= '0;
      rsp_miss_o  <= '0;
      rsp_ppn_o   <= '0;
    end else begin
      valid_q <= valid_d;
      if (wr_en) begin
        vpn_q[wr_idx]  <= wr_vpn;
        ppn_q[wr_idx]  <= wr_ppn;
        pcid_q[wr_idx] <= wr_pcid;
        if (!wr_hit && use_ptr) begin
          if (mode_shared_i)
            ptr_all_q <= (ptr_all_q == IDX_W'(N-1)) ? '0 : ptr_all_q + 1'b1;
          else if (wr_thread)
            ptr_hi_q <= (ptr_hi_q == IDX_W'(N-1)) ? IDX_W'(HALF) : ptr_hi_q + 1'b1;
          else
            ptr_lo_q <= (ptr_lo_q == IDX_W'(HALF-1)) ? '0 : ptr_lo_q + 1'b1;
        end
      end
      if (fill_valid_i[0] && fill_valid_i[1] && !pend_q) begin
        pend_q      <= 1'b1;
        pend_vpn_q  <= fill_vpn_i[1];
        pend_ppn_q  <= fill_ppn_i[1];
        pend_pcid_q <= cur_pcid[1];
      end else if (pend_q && !fill_valid_i[0]) begin
        pend_q <= 1'b0;
      end
      for (int t = 0; t < NT; t++) begin
        if (cr3_we_i[t]) cr3_q[t] <= cr3_data_i[t];
        rsp_hit_o[t]  <= lk_valid_i[t] && lk_hit[t];
        rsp_miss_o[t] <= lk_valid_i[t] && !lk_hit[t];
        rsp_ppn_o[t]  <= (lk_valid_i[t] && lk_hit[t]) ? ppn_q[lk_idx[t]] : '0;
      end
    end
  end
endmodule

// File: rtl/smt_tlb_chk.sv
module smt_tlb_chk #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_shared_i,
  input logic [1:0]       lk_valid_i,
  input logic [1:0]       rsp_hit_o,
  input logic [1:0]       rsp_miss_o,
  input logic             inv_valid_i,
  input logic [1:0]       inv_op_i,
  input logic [N-1:0]     valid_q,
  input logic             wr_en,
  input logic             wr_thread,
  input logic [IDX_W-1:0] wr_idx
);
  localparam int HALF = N / 2;
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  assert_hit_miss_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_hit_o & rsp_miss_o) == 2'b00);

  assert_rsp_next_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((rsp_hit_o | rsp_miss_o) == $past(lk_valid_i)));

  assert_no_drop_without_inv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(inv_valid_i)) |-> (($past(valid_q) & ~valid_q) == '0));

  assert_inv_all_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_i && inv_op_i == 2'd0 && !wr_en) |=> (valid_q == '0));

  assert_part_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !mode_shared_i && !wr_thread) |-> (int'(wr_idx) < HALF));

  assert_part_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !mode_shared_i && wr_thread) |-> (int'(wr_idx) >= HALF));

  assert_fill_lands_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> valid_q[$past(wr_idx)]);
endmodule

bind smt_tlb smt_tlb_chk #(.N(N), .IDX_W(IDX_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_shared_i(mode_shared_i),
  .lk_valid_i(lk_valid_i), .rsp_hit_o(rsp_hit_o), .rsp_miss_o(rsp_miss_o),
  .inv_valid_i(inv_valid_i), .inv_op_i(inv_op_i), .valid_q(valid_q),
  .wr_en(wr_en), .wr_thread(wr_thread), .wr_idx(wr_idx));

// File: tb/smt_tlb_tb_top.sv
module smt_tlb_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_shared_i = 1'b1;
  logic [1:0]        lk_valid_i = '0;
  logic [1:0][35:0]  lk_vpn_i = '0;
  logic [1:0]        rsp_hit_o, rsp_miss_o;
  logic [1:0][27:0]  rsp_ppn_o;
  logic [1:0]        fill_valid_i = '0;
  logic [1:0][35:0]  fill_vpn_i = '0;
  logic [1:0][27:0]  fill_ppn_i = '0;
  logic [1:0]        cr3_we_i = '0;
  logic [1:0][63:0]  cr3_data_i = '0;
  logic              inv_valid_i = 1'b0;
  logic [1:0]        inv_op_i = '0;
  logic [11:0]       inv_pcid_i = '0;
  logic [35:0]       inv_vpn_i = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  smt_tlb dut_i (.*);

  // {op[1:0], thr, exp_hit, req[3:0], vpn[15:0], data[15:0]}; op 0 cr3, 1 fill, 2 lookup
  localparam int NV = 15;
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 4'd3,  16'h0000, 16'h0005},
    {2'd0, 1'b1, 1'b0, 4'd3,  16'h0000, 16'h0009},
    {2'd2, 1'b0, 1'b0, 4'd2,  16'h000A, 16'h0000},  // R2 miss on empty
    {2'd1, 1'b0, 1'b0, 4'd3,  16'h000A, 16'h0100},
    {2'd2, 1'b0, 1'b1, 4'd3,  16'h000A, 16'h0100},  // R3 hit
    {2'd2, 1'b1, 1'b0, 4'd3,  16'h000A, 16'h0000},  // R3 PCID mismatch
    {2'd1, 1'b1, 1'b0, 4'd4,  16'h000A, 16'h0200},
    {2'd2, 1'b0, 1'b1, 4'd4,  16'h000A, 16'h0100},  // R4
    {2'd2, 1'b1, 1'b1, 4'd4,  16'h000A, 16'h0200},  // R4
    {2'd0, 1'b0, 1'b0, 4'd5,  16'h0000, 16'h0007},
    {2'd2, 1'b0, 1'b0, 4'd5,  16'h000A, 16'h0000},  // R5 other space
    {2'd0, 1'b0, 1'b0, 4'd5,  16'h0000, 16'h0005},
    {2'd2, 1'b0, 1'b1, 4'd5,  16'h000A, 16'h0100},  // R5 survives switch
    {2'd1, 1'b0, 1'b0, 4'd10, 16'h000A, 16'h0111},
    {2'd2, 1'b0, 1'b1, 4'd10, 16'h000A, 16'h0111}   // R10 in-place refill
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_lookup(input int t, input logic [35:0] v, input bit eh,
                           input logic [27:0] ep, input string req);
    lk_valid_i[t] = 1'b1; lk_vpn_i[t] = v;
    @(posedge clk_i); @(negedge clk_i);
    lk_valid_i = '0;
    check(rsp_hit_o[t] == eh && rsp_miss_o[t] == !eh, req,
          {62'd0, rsp_hit_o[t], rsp_miss_o[t]}, {62'd0, eh, !eh});
    if (eh) check(rsp_ppn_o[t] == ep, req, 64'(rsp_ppn_o[t]), 64'(ep));
  endtask

  task automatic do_fill(input int t, input logic [35:0] v, input logic [27:0] p);
    fill_valid_i[t] = 1'b1; fill_vpn_i[t] = v; fill_ppn_i[t] = p;
    @(posedge clk_i); @(negedge clk_i);
    fill_valid_i = '0;
  endtask

  task automatic do_cr3(input int t, input logic [63:0] d);
    cr3_we_i[t] = 1'b1; cr3_data_i[t] = d;
    @(posedge clk_i); @(negedge clk_i);
    cr3_we_i = '0;
  endtask

  task automatic do_inv(input logic [1:0] op, input logic [11:0] pc, input logic [35:0] v);
    inv_valid_i = 1'b1; inv_op_i = op; inv_pcid_i = pc; inv_vpn_i = v;
    @(posedge clk_i); @(negedge clk_i);
    inv_valid_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    check(rsp_hit_o == 0 && rsp_miss_o == 0, "R1", {60'd0, rsp_hit_o, rsp_miss_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(rsp_hit_o == 0 && rsp_miss_o == 0, "R2 idle", {60'd0, rsp_hit_o, rsp_miss_o}, 64'd0);
    do_lookup(0, 36'd0, 1'b0, '0, "R1");
    do_lookup(1, 36'd0, 1'b0, '0, "R1");

    for (int i = 0; i < NV; i++) begin
      logic [39:0] e;
      e = VEC[i];
      case (e[39:38])
        2'd0: do_cr3(int'(e[37]), {48'd0, e[15:0]});
        2'd1: do_fill(int'(e[37]), {20'd0, e[31:16]}, {12'd0, e[15:0]});
        default: do_lookup(int'(e[37]), {20'd0, e[31:16]}, e[36], {12'd0, e[15:0]},
                           $sformatf("R%0d vec%0d", e[35:32], i));
      endcase
    end

    // R6 partitioned: same PCID, other half invisible
    do_reset();
    mode_shared_i = 1'b0;
    do_cr3(0, 64'h3); do_cr3(1, 64'h3);
    do_fill(0, 36'h40, 28'h1);
    do_lookup(1, 36'h40, 1'b0, '0, "R6 cross-half");
    do_lookup(0, 36'h40, 1'b1, 28'h1, "R6 own half");
    mode_shared_i = 1'b1;
    @(negedge clk_i);
    do_lookup(1, 36'h40, 1'b1, 28'h1, "R7 shared sees entry");

    // R8 partitioned capacity N/2, round-robin per half
    do_reset();
    mode_shared_i = 1'b0;
    do_cr3(0, 64'h1);
    for (int v = 0; v < 9; v++) do_fill(0, 36'(v), 28'(v + 'h100));
    do_lookup(0, 36'd0, 1'b0, '0, "R8 partition evicts oldest");
    for (int v = 1; v < 9; v++) do_lookup(0, 36'(v), 1'b1, 28'(v + 'h100), "R8 partition kept");

    // R7 shared capacity N
    do_reset();
    mode_shared_i = 1'b1;
    do_cr3(0, 64'h1); do_cr3(1, 64'h2);
    for (int v = 0; v < 16; v++) do_fill(0, 36'(v), 28'(v + 'h200));
    for (int v = 0; v < 16; v++) do_lookup(0, 36'(v), 1'b1, 28'(v + 'h200), "R7 all resident");
    do_fill(0, 36'd16, 28'h210);
    do_lookup(0, 36'd0, 1'b0, '0, "R8 rr victim 0");
    do_lookup(0, 36'd16, 1'b1, 28'h210, "R8 new entry");
    // R9 page invalidate, then R8 invalid-first reuse
    do_inv(2'd2, 12'h1, 36'd5);
    do_lookup(0, 36'd5, 1'b0, '0, "R9 page flush");
    do_lookup(0, 36'd6, 1'b1, 28'h206, "R9 page flush neighbour");
    do_fill(0, 36'd20, 28'h220);
    do_lookup(0, 36'd1, 1'b1, 28'h201, "R8 invalid preferred");
    do_lookup(0, 36'd20, 1'b1, 28'h220, "R8 freed slot used");
    // R9 PCID flush and flush-all
    do_inv(2'd0, 12'h0, 36'd0);
    do_fill(0, 36'd1, 28'h301);
    do_fill(1, 36'd30, 28'h330);
    do_inv(2'd1, 12'h1, 36'd0);
    do_lookup(0, 36'd1, 1'b0, '0, "R9 pcid flush");
    do_lookup(1, 36'd30, 1'b1, 28'h330, "R9 other pcid kept");
    do_inv(2'd0, 12'h0, 36'd0);
    do_lookup(1, 36'd30, 1'b0, '0, "R9 flush all");

    // R11 simultaneous fills
    fill_valid_i = 2'b11;
    fill_vpn_i[0] = 36'h60; fill_ppn_i[0] = 28'h60;
    fill_vpn_i[1] = 36'h61; fill_ppn_i[1] = 28'h61;
    @(posedge clk_i); @(negedge clk_i);
    fill_valid_i = '0;
    lk_valid_i = 2'b11; lk_vpn_i[0] = 36'h60; lk_vpn_i[1] = 36'h61;
    @(posedge clk_i); @(negedge clk_i);
    lk_valid_i = '0;
    check(rsp_hit_o[0] == 1'b1, "R11 thread0 first", 64'(rsp_hit_o[0]), 64'd1);
    check(rsp_miss_o[1] == 1'b1, "R11 thread1 held", 64'(rsp_miss_o[1]), 64'd1);
    do_lookup(1, 36'h61, 1'b1, 28'h61, "R11 thread1 written later");
    do_cr3(1, 64'h9);
    do_lookup(1, 36'h61, 1'b0, '0, "R11 held fill kept its PCID");

    finish_run();
  end
endmodule